// File: doc/BRIEF.md
# Threshold Offset Register Loader

This block holds the two thresholds that a FIFO's almost-empty and almost-full flags compare against: the empty offset n and the full offset m. Each threshold is as wide as a FIFO word address. It is split into a low byte and a high part, and the high part holds the address bits above bit 7. Software loads and inspects these thresholds through the FIFO's own pins. The data inputs and the write enable carry load data on the write clock. The two read enables request readback on the read clock. A shared pin acts either as a second write enable or as an active-low load strobe.

The level of the shared pin while reset is held decides its role, and that role then stays fixed until the next reset. A high level selects the dual-write-enable role, in which the thresholds keep their defaults. A low level selects load mode. In load mode the block accesses the four threshold slots in a fixed rotating order. A write selector runs in the write clock domain and a readback selector runs in the read clock domain. Each selector keeps its position when the strobe goes high, so a later session carries on from where the last one stopped.

The data interfaces have no back-pressure. An access happens on the clock edge where its enables are asserted. Readback data arrives with a one-cycle `rb_valid` pulse, and the FIFO output register always accepts it. Loading and readback must not overlap, and the thresholds are treated as quasi-static by the flag logic.

Top module: `otl_offset_loader`

## Requirements
- R1: While `rst_n` is low, the block samples `wen2_ld` on every rising `wclk` and `rclk`. After release, `load_mode` is 1 if `wen2_ld` was low at the last reset edge and 0 if it was high. `load_mode` does not change until the next reset.
- R2: After reset, `empty_off` and `full_off` both equal 7, `rb_valid` is 0 and `rb_data` is 0.
- R3: In load mode, each rising `wclk` with `wen2_ld` low and `wen1_n` low stores `din` into the slot chosen by the write selector, then advances the selector. The slot order is 0 (empty low byte, `empty_off[7:0]`), 1 (empty high part), 2 (full low byte, `full_off[7:0]`), 3 (full high part).
- R4: The load write after the one to slot 3 goes to slot 0.
- R5: Raising `wen2_ld` or holding `wen1_n` high keeps the write selector where it is. The next load write goes to the following slot in the order.
- R6: In load mode, each rising `rclk` with `wen2_ld`, `ren1_n` and `ren2_n` all low puts the slot chosen by the readback selector on `rb_data`. A high part appears zero-extended to 8 bits. `rb_valid` is high for that one cycle, then the readback selector advances through the same order. At all other times `rb_valid` is 0 and `rb_data` holds its value.
- R7: `fifo_wr_req` is 1 exactly when `wen1_n` is low and `wen2_ld` is high, in either mode. A rising `wclk` with `wen2_ld` low and `wen1_n` high leaves both offsets unchanged.
- R8: In dual-write-enable mode, no input pattern changes the offsets from 7, and `rb_valid` stays 0.
- R9: The high part is HI_W = log2(DEPTH) - 8 bits wide and takes `din[HI_W-1:0]`. The bits of `din` above it are ignored.
- R10: `fifo_rd_req` is 1 exactly when both read enables are low and either `load_mode` is 0 or `wen2_ld` is high.
- R11: Reset returns both selectors to slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| rst_n | input | 1 | Synchronous active-low reset, sampled by both clocks |
| wen1_n | input | 1 | Active-low primary write enable |
| wen2_ld | input | 1 | Shared pin: active-high second write enable, or active-low load strobe |
| ren1_n | input | 1 | Active-low read enable one |
| ren2_n | input | 1 | Active-low read enable two |
| din | input | 9 | FIFO data inputs; the low bits carry threshold bytes |
| empty_off | output | log2(DEPTH) | Empty threshold n |
| full_off | output | log2(DEPTH) | Full threshold m |
| load_mode | output | 1 | 1 when the shared pin is the load strobe |
| fifo_wr_req | output | 1 | Decoded FIFO write request |
| fifo_rd_req | output | 1 | Decoded FIFO read request |
| rb_valid | output | 1 | One-cycle pulse when readback data is presented |
| rb_data | output | 8 | Readback byte for the low FIFO output bits |

## Verification
The hardest state to reach from the ports is the two selectors standing at different slots after several partial sessions. To get there, sessions must end and restart at arbitrary points, and a reset must be able to catch a selector in the middle of its order. The stimulus runs a long constrained-random stretch. In that stretch the strobe toggles often, and load writes and readbacks occur in random runs, never on the same edge. A bench model tracks both selector positions and all four slots, and the run checks offsets and readback bytes on every cycle. Directed steps before and after the random stretch cover the wrap and the width masking of the high part. They also cover a reset taken mid-sequence and the mode chosen by the pin.

// File: rtl/otl_pkg.sv
package otl_pkg;
  typedef enum logic [1:0] {
    SLOT_E_LO = 2'd0,
    SLOT_E_HI = 2'd1,
    SLOT_F_LO = 2'd2,
    SLOT_F_HI = 2'd3
  } slot_e;

  localparam int NUM_SLOTS = 4;
  localparam logic [7:0] DEFAULT_LO = 8'h07;

  function automatic slot_e next_slot(input slot_e s);
    return slot_e'(s + 2'd1);
  endfunction
endpackage

// File: rtl/otl_mode_latch.sv
module otl_mode_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic load_mode
);
  // Keeps sampling the pin while reset is held; the last sample wins.
  always_ff @(posedge clk) begin
    if (!rst_n) load_mode <= ~pin;
  end
endmodule

// File: rtl/otl_ring_sel.sv
module otl_ring_sel
  import otl_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  adv,
  output slot_e slot
);
  always_ff @(posedge clk) begin
    if (!rst_n)   slot <= SLOT_E_LO;
    else if (adv) slot <= next_slot(slot);
  end
endmodule

// File: rtl/otl_offset_bank.sv
module otl_offset_bank
  import otl_pkg::*;
#(
  parameter int HI_W = 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  slot_e           slot,
  input  logic [7:0]      wdata,
  output logic [3:0][7:0] regs_q
);
  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    localparam int W = (g % 2 == 0) ? 8 : HI_W;
    localparam logic [7:0] RST = (g % 2 == 0) ? DEFAULT_LO : 8'h00;
    logic hit;
    assign hit = we && (slot == slot_e'(g));
    if (W == 8) begin : g_full
      always_ff @(posedge clk) begin
        if (!rst_n)   regs_q[g] <= RST;
        else if (hit) regs_q[g] <= wdata;
      end
    end else begin : g_part
      // Upper byte bits stay zero so readback sees a zero-extended value.
      always_ff @(posedge clk) begin
        if (!rst_n)   regs_q[g] <= RST;
        else if (hit) regs_q[g] <= {{(8 - W){1'b0}}, wdata[W-1:0]};
      end
    end
  end
endmodule

// File: rtl/otl_readback.sv
module otl_readback
  import otl_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rd,
  input  slot_e           slot,
  input  logic [3:0][7:0] regs_q,
  output logic            rb_valid,
  output logic [7:0]      rb_data
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rb_valid <= 1'b0;
      rb_data  <= 8'h00;
    end else begin
      rb_valid <= rd;
      if (rd) rb_data <= regs_q[slot];
    end
  end
endmodule

// File: rtl/otl_offset_loader.sv
module otl_offset_loader
  import otl_pkg::*;
#(
  parameter int DEPTH = 512,
  localparam int OFF_W = $clog2(DEPTH),
  localparam int HI_W = OFF_W - 8
) (
  input  logic             wclk,
  input  logic             rclk,
  input  logic             rst_n,
  input  logic             wen1_n,
  input  logic             wen2_ld,
  input  logic             ren1_n,
  input  logic             ren2_n,
  input  logic [8:0]       din,
  output logic [OFF_W-1:0] empty_off,
  output logic [OFF_W-1:0] full_off,
  output logic             load_mode,
  output logic             fifo_wr_req,
  output logic             fifo_rd_req,
  output logic             rb_valid,
  output logic [7:0]       rb_data
);
  logic            mode_w, mode_r;
  logic            ld_wr, ld_rd, rd_both;
  slot_e           wslot, rslot;
  logic [3:0][7:0] regs_q;

  // Each clock domain latches the pin role itself.
  otl_mode_latch u_mode_w (.clk(wclk), .rst_n(rst_n), .pin(wen2_ld), .load_mode(mode_w));
  otl_mode_latch u_mode_r (.clk(rclk), .rst_n(rst_n), .pin(wen2_ld), .load_mode(mode_r));

  assign rd_both = ~ren1_n & ~ren2_n;
  assign ld_wr   = mode_w & ~wen2_ld & ~wen1_n;
  assign ld_rd   = mode_r & ~wen2_ld & rd_both;

  otl_ring_sel u_wsel (.clk(wclk), .rst_n(rst_n), .adv(ld_wr), .slot(wslot));
  otl_ring_sel u_rsel (.clk(rclk), .rst_n(rst_n), .adv(ld_rd), .slot(rslot));

  otl_offset_bank #(.HI_W(HI_W)) u_bank (
    .clk(wclk), .rst_n(rst_n), .we(ld_wr), .slot(wslot),
    .wdata(din[7:0]), .regs_q(regs_q)
  );

  otl_readback u_rb (
    .clk(rclk), .rst_n(rst_n), .rd(ld_rd), .slot(rslot),
    .regs_q(regs_q), .rb_valid(rb_valid), .rb_data(rb_data)
  );

  assign empty_off   = {regs_q[SLOT_E_HI][HI_W-1:0], regs_q[SLOT_E_LO]};
  assign full_off    = {regs_q[SLOT_F_HI][HI_W-1:0], regs_q[SLOT_F_LO]};
  assign load_mode   = mode_w;
  assign fifo_wr_req = ~wen1_n & wen2_ld;
  assign fifo_rd_req = rd_both & (~mode_r | wen2_ld);
endmodule

// File: rtl/otl_offset_loader_chk.sv
module otl_offset_loader_chk #(
  parameter int OFF_W = 9
) (
  input logic             wclk,
  input logic             rclk,
  input logic             rst_n,
  input logic             wen1_n,
  input logic             wen2_ld,
  input logic             ren1_n,
  input logic             ren2_n,
  input logic [OFF_W-1:0] empty_off,
  input logic [OFF_W-1:0] full_off,
  input logic             load_mode,
  input logic             fifo_wr_req,
  input logic             rb_valid
);
  AST_MODE_HELD: assert property (@(posedge wclk) disable iff (!rst_n)
    1'b1 |=> $stable(load_mode)); // R1

  AST_IDLE_OFFS_HELD: assert property (@(posedge wclk) disable iff (!rst_n)
    (wen2_ld || wen1_n) |=> ($stable(empty_off) && $stable(full_off))); // R7

  AST_FIFO_WR_NO_LOAD: assert property (@(posedge wclk) disable iff (!rst_n)
    fifo_wr_req |=> ($stable(empty_off) && $stable(full_off))); // R7

  AST_DUAL_OFFS_FIXED: assert property (@(posedge wclk) disable iff (!rst_n)
    !load_mode |-> (empty_off == OFF_W'(7) && full_off == OFF_W'(7))); // R8

  AST_RB_NEEDS_REQ: assert property (@(posedge rclk) disable iff (!rst_n)
    rb_valid |-> ($past(!ren1_n && !ren2_n && !wen2_ld))); // R6
endmodule

bind otl_offset_loader otl_offset_loader_chk #(.OFF_W(OFF_W)) u_chk (
  .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .wen1_n(wen1_n), .wen2_ld(wen2_ld),
  .ren1_n(ren1_n), .ren2_n(ren2_n), .empty_off(empty_off), .full_off(full_off),
  .load_mode(load_mode), .fifo_wr_req(fifo_wr_req), .rb_valid(rb_valid)
);

// File: tb/otl_offset_loader_tb.sv
module otl_offset_loader_tb;
  localparam int DEPTH = 512;
  localparam int OFF_W = $clog2(DEPTH);
  localparam int HI_W  = OFF_W - 8;

  logic wclk = 1'b0, rclk = 1'b0;
  logic rst_n = 1'b0, wen1_n = 1'b1, wen2_ld = 1'b1, ren1_n = 1'b1, ren2_n = 1'b1;
  logic [8:0] din = '0;
  logic [OFF_W-1:0] empty_off, full_off;
  logic load_mode, fifo_wr_req, fifo_rd_req, rb_valid;
  logic [7:0] rb_data;

  always #5 wclk = ~wclk;
  initial begin #3; forever #5 rclk = ~rclk; end

  otl_offset_loader #(.DEPTH(DEPTH)) u_dut (
    .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .wen1_n(wen1_n), .wen2_ld(wen2_ld),
    .ren1_n(ren1_n), .ren2_n(ren2_n), .din(din), .empty_off(empty_off),
    .full_off(full_off), .load_mode(load_mode), .fifo_wr_req(fifo_wr_req),
    .fifo_rd_req(fifo_rd_req), .rb_valid(rb_valid), .rb_data(rb_data)
  );

  int n_chk = 0, n_err = 0;
  bit done = 0;
  logic [7:0] mreg [4];
  int wsel, rsel;
  bit ml;
  logic [7:0] exp_rb;
  bit exp_rbv;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] slot_val(input logic [8:0] d, input int s);
    return (s % 2 == 1) ? (d[7:0] & 8'((1 << HI_W) - 1)) : d[7:0];
  endfunction

  function automatic logic [OFF_W-1:0] exp_off(input int base);
    return {mreg[base+1][HI_W-1:0], mreg[base]};
  endfunction

  task automatic do_reset(input logic pin);
    @(negedge wclk);
    rst_n = 1'b0; wen2_ld = pin; wen1_n = 1'b1; ren1_n = 1'b1; ren2_n = 1'b1;
    repeat (3) @(negedge wclk);
    rst_n = 1'b1;
    mreg[0] = 8'h07; mreg[1] = 8'h00; mreg[2] = 8'h07; mreg[3] = 8'h00;
    wsel = 0; rsel = 0; ml = ~pin; exp_rb = 8'h00; exp_rbv = 0;
    @(negedge wclk);
    chk("R1 load_mode", load_mode, ml);
    chk("R2 empty_off", empty_off, 7);
    chk("R2 full_off", full_off, 7);
    chk("R2 rb_valid", rb_valid, 0);
    chk("R2 rb_data", rb_data, 0);
  endtask

  // Called just after a falling wclk; applies one cycle and checks it.
  task automatic step(input logic w1, input logic ld, input logic r1, input logic r2,
                      input logic [8:0] d, input string tag);
    wen1_n = w1; wen2_ld = ld; ren1_n = r1; ren2_n = r2; din = d;
    exp_rbv = 0;
    if (ml && !ld && !r1 && !r2) begin
      exp_rb = mreg[rsel]; exp_rbv = 1; rsel = (rsel + 1) % 4;
    end
    if (ml && !ld && !w1) begin
      mreg[wsel] = slot_val(d, wsel); wsel = (wsel + 1) % 4;
    end
    @(negedge wclk);
    chk({tag, " empty_off"}, empty_off, exp_off(0));
    chk({tag, " full_off"}, full_off, exp_off(2));
    chk("R6 rb_valid", rb_valid, exp_rbv);
    chk("R6 rb_data", rb_data, exp_rb);
    chk("R7 fifo_wr_req", fifo_wr_req, !w1 && ld);
    chk("R10 fifo_rd_req", fifo_rd_req, !r1 && !r2 && (!ml || ld));
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    do_reset(1'b0);
    // R3: one full pass in order, with upper din bits on high parts (R9)
    step(0, 0, 1, 1, 9'h0A5, "R3");
    step(0, 0, 1, 1, 9'h1FF, "R9");
    step(0, 0, 1, 1, 9'h03C, "R3");
    step(0, 0, 1, 1, 9'h0FE, "R9");
    chk("R3 empty_off", empty_off, {1'b1, 8'hA5});
    chk("R9 full_off", full_off, {1'b0, 8'h3C});
    // R4: fifth write wraps to slot 0
    step(0, 0, 1, 1, 9'h011, "R4");
    chk("R4 empty_off low byte", empty_off[7:0], 8'h11);
    // R5: partial session then continue; R7: strobe low with wen1 high is a no-op
    step(1, 1, 1, 1, 9'h0EE, "R5");
    step(1, 0, 1, 1, 9'h0DD, "R7");
    step(0, 0, 1, 1, 9'h000, "R5");
    chk("R5 empty_off high part", empty_off[8], 1'b0);
    // R6: readback in order, high part zero-extended
    for (int i = 0; i < 5; i++) step(1, 0, 0, 0, 9'h000, "R6");
    // R11: reset mid-sequence, first write then lands in slot 0
    step(0, 0, 1, 1, 9'h044, "R3");
    do_reset(1'b0);
    step(0, 0, 1, 1, 9'h099, "R11");
    chk("R11 empty_off", empty_off, {1'b0, 8'h99});
    step(1, 0, 0, 0, 9'h000, "R11");
    chk("R11 readback slot0", rb_data, 8'h99);
    // Random sessions
    for (int i = 0; i < 600; i++) begin
      logic ld, w1, r1, r2;
      int op;
      ld = ($urandom % 4) == 0;
      op = $urandom % 3;
      w1 = (op != 0); r1 = (op != 1); r2 = (op != 1);
      if (op == 2) begin r1 = $urandom; r2 = 1'b1; w1 = $urandom; end
      if (ld) begin w1 = $urandom; r1 = $urandom; r2 = $urandom; end
      step(w1, ld, r1, r2, 9'($urandom), "R5");
    end
    // R8: dual-write-enable mode ignores load patterns
    do_reset(1'b1);
    step(0, 0, 1, 1, 9'h1AB, "R8");
    step(1, 0, 0, 0, 9'h000, "R8");
    step(0, 1, 0, 0, 9'h055, "R8");
    step(1, 1, 0, 1, 9'h000, "R8");
    chk("R8 empty_off", empty_off, 7);
    chk("R1 load_mode held", load_mode, 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule